// File: doc/BRIEF.md
# Single/Dual Address DMA Channel Engine

This block is one DMA channel. It moves a programmed number of transfer units from a source endpoint to a destination endpoint through a simple bus-master port. The port carries address, read and write strobes, a beat size, write data, read data and a ready input. Configuration comes in on ports and is sampled when `start` is accepted. It gives the type of each endpoint, the two start addresses, the unit count, the unit size, an increment enable for each side and the bus mode. An external device that uses a request/acknowledge handshake is paced by `dreq`, and the engine selects it with `dack`.

When a start is accepted, the engine checks whether the pairing of endpoint types, the unit size and the count are legal. If they are not, it raises `error` and issues no bus cycle. If they are legal, it runs in one of two address modes. Dual-address mode reads each beat into an internal 32-bit hold register and then writes that register to the destination. Single-address mode issues one bus cycle per beat at the memory-side address and raises `dack` to select the device. In cycle-steal mode the bus is released after every unit. In burst mode it is kept until the last unit.

The controller is a state machine with seven states. ST_IDLE waits for an accepted start: it goes to ST_WREQ in single mode and to ST_READ in dual mode. ST_WREQ waits for `dreq` and then goes to ST_SINGLE. ST_READ goes to ST_WRITE on ready. ST_WRITE and ST_SINGLE stay in the access loop on ready while beats remain in the unit. At the end of a unit they go to ST_DONE if it was the last unit. Otherwise they restart the access loop in burst mode, or go to ST_GAP in cycle-steal mode. ST_GAP lasts one cycle and returns to ST_WREQ (single mode) or ST_READ (dual mode). ST_DONE lasts one cycle and returns to ST_IDLE.

Top module: `dma_channel`

## Requirements
- R1: Endpoint type codes are 0 handshake device, 1 external memory, 2 memory-mapped device, 3 on-chip peripheral, 4 X/Y memory; codes 5 to 7 are illegal. Also illegal are device-to-device, a device paired with code 3 or 4 in either direction, and a count of zero. On an illegal start, `error` is 1 from the next cycle, `busy` stays 0 and no bus cycle occurs.
- R2: Unit size code 3 (16 bytes) is illegal when either endpoint has type code 3.
- R3: Any pairing among codes 1 to 4 runs in dual-address mode. Each beat is a read at the source address, then a write of exactly the read data to the destination address.
- R4: A device (code 0) paired with code 1 or 2 runs in single-address mode. There is one bus cycle per beat at the memory-side address, and `dack` is high during those cycles and no others. The cycle is a read when the device is the destination and a write when it is the source.
- R5: Unit size codes 0, 1, 2 and 3 mean 1, 2, 4 and 16 bytes. `bus_size` carries 0, 1 or 2 for 1-, 2- or 4-byte beats. A 16-byte unit is four 4-byte beats, at offsets 0, 4, 8 and 12 on an incrementing side and at one fixed address on a non-incrementing side.
- R6: After each unit, a side whose increment enable is 1 advances its address by the unit size in bytes. A side whose increment enable is 0 keeps its address.
- R7: In cycle-steal mode, `bus_req` falls between units, so it rises once per unit. In burst mode it rises once per transfer.
- R8: In cycle-steal mode with a device endpoint, each unit waits for `dreq` to be high, and no bus cycle occurs while it is low. In burst mode, `dreq` is sampled only before the first unit.
- R9: `done` is a one-cycle pulse after the final beat of the last unit, and `busy` is 0 in the cycle after it. A legal start clears `error`.
- R10: `start` is ignored while `busy` is 1, including the cycle in which `done` is high.
- R11: A bus access with `bus_ready` low holds its address and strobes unchanged until ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start request, sampled when idle |
| src_type | input | 3 | Source endpoint type code |
| dst_type | input | 3 | Destination endpoint type code |
| src_addr | input | AW | Source start address |
| dst_addr | input | AW | Destination start address |
| xfer_count | input | CW | Number of units |
| unit_size | input | 2 | Unit size code |
| src_inc | input | 1 | Source address increment enable |
| dst_inc | input | 1 | Destination address increment enable |
| burst_mode | input | 1 | 1 burst, 0 cycle-steal |
| dreq | input | 1 | Device transfer request |
| dack | output | 1 | Device select during single-address cycles |
| bus_req | output | 1 | Bus held by the channel |
| bus_addr | output | AW | Bus address |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| bus_size | output | 2 | Beat size code |
| bus_wdata | output | 32 | Write data from the hold register |
| bus_rdata | input | 32 | Read data |
| bus_ready | input | 1 | Access completes this cycle |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Completion pulse |
| error | output | 1 | Last start was rejected |

## Verification
Two functions can fall in the same cycle: the completion pulse and a new start request. The bench raises `start` with a legal configuration exactly in the cycle where it sees `done` high. It then requires that no further bus beat, no second `done` pulse and no return of `busy` follows over the next cycles. A second overlap arises in cycle-steal single-address runs: a beat completes in the same cycle that the device drops `dreq`. The bench checks that every rise of `dack` was preceded by `dreq` being high.

// File: rtl/dma_pkg.sv
package dma_pkg;

    localparam logic [2:0] EP_DACK  = 3'd0;
    localparam logic [2:0] EP_XMEM  = 3'd1;
    localparam logic [2:0] EP_MMIO  = 3'd2;
    localparam logic [2:0] EP_PERI  = 3'd3;
    localparam logic [2:0] EP_XYMEM = 3'd4;

    localparam logic [1:0] SZ_1  = 2'd0;
    localparam logic [1:0] SZ_2  = 2'd1;
    localparam logic [1:0] SZ_4  = 2'd2;
    localparam logic [1:0] SZ_16 = 2'd3;

    localparam int BEAT_LG    = 2;
    localparam int LINE_BEATS = 4;
    localparam int BEAT_IDX_W = $clog2(LINE_BEATS);
    localparam int DW         = 8 << BEAT_LG;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WREQ,
        ST_READ,
        ST_WRITE,
        ST_SINGLE,
        ST_GAP,
        ST_DONE
    } dma_state_t;

    function automatic logic [4:0] unit_bytes(input logic [1:0] sz);
        logic [4:0] b;
        unique case (sz)
            SZ_1:    b = 5'd1;
            SZ_2:    b = 5'd2;
            SZ_4:    b = 5'd4;
            default: b = 5'd16;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/dma_legal.sv
module dma_legal
    import dma_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic [2:0]    src_type,
    input  logic [2:0]    dst_type,
    input  logic [1:0]    unit_size,
    input  logic [CW-1:0] xfer_count,
    output logic          cfg_ok,
    output logic          single_mode,
    output logic          dev_is_src
);

    localparam int SIDES = 2;

    logic [2:0]       ep [SIDES];
    logic [SIDES-1:0] is_dev;
    logic [SIDES-1:0] is_ext;
    logic [SIDES-1:0] is_peri;
    logic [SIDES-1:0] is_known;
    logic             pair_ok;

    assign ep[0] = src_type;
    assign ep[1] = dst_type;

    for (genvar i = 0; i < SIDES; i++) begin : g_side
        assign is_dev[i]   = (ep[i] == EP_DACK);
        assign is_ext[i]   = (ep[i] == EP_XMEM) || (ep[i] == EP_MMIO);
        assign is_peri[i]  = (ep[i] == EP_PERI);
        assign is_known[i] = (ep[i] <= EP_XYMEM);
    end

    always_comb begin
        if (is_dev == '0) begin
            pair_ok = 1'b1;
        end else begin
            pair_ok = (is_dev[0] && is_ext[1]) || (is_dev[1] && is_ext[0]);
        end
    end

    assign cfg_ok      = (&is_known) && pair_ok && (xfer_count != '0)
                         && !((unit_size == SZ_16) && (|is_peri));
    assign single_mode = |is_dev;
    assign dev_is_src  = is_dev[0];

endmodule

// File: rtl/dma_xfer_regs.sv
module dma_xfer_regs
    import dma_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          beat_adv,
    input  logic          unit_adv,
    input  logic [AW-1:0] src_addr,
    input  logic [AW-1:0] dst_addr,
    input  logic [CW-1:0] xfer_count,
    input  logic [1:0]    unit_size,
    input  logic          src_inc,
    input  logic          dst_inc,
    output logic [AW-1:0] src_beat_addr,
    output logic [AW-1:0] dst_beat_addr,
    output logic          last_beat,
    output logic          last_unit,
    output logic [1:0]    beat_size
);

    localparam int OFF_PAD = AW - BEAT_IDX_W - BEAT_LG;

    logic [AW-1:0]         src_cur;
    logic [AW-1:0]         dst_cur;
    logic [CW-1:0]         cnt_rem;
    logic [BEAT_IDX_W-1:0] beat;
    logic [1:0]            size_l;
    logic                  sinc_l;
    logic                  dinc_l;
    logic [AW-1:0]         step;
    logic [AW-1:0]         beat_off;

    assign step     = {{(AW-5){1'b0}}, unit_bytes(size_l)};
    assign beat_off = {{OFF_PAD{1'b0}}, beat, {BEAT_LG{1'b0}}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_cur <= '0;
            dst_cur <= '0;
            cnt_rem <= '0;
            beat    <= '0;
            size_l  <= SZ_1;
            sinc_l  <= 1'b0;
            dinc_l  <= 1'b0;
        end else if (load) begin
            src_cur <= src_addr;
            dst_cur <= dst_addr;
            cnt_rem <= xfer_count;
            beat    <= '0;
            size_l  <= unit_size;
            sinc_l  <= src_inc;
            dinc_l  <= dst_inc;
        end else if (unit_adv) begin
            cnt_rem <= cnt_rem - 1'b1;
            beat    <= '0;
            if (sinc_l) src_cur <= src_cur + step;
            if (dinc_l) dst_cur <= dst_cur + step;
        end else if (beat_adv) begin
            beat <= beat + 1'b1;
        end
    end

    assign src_beat_addr = sinc_l ? (src_cur + beat_off) : src_cur;
    assign dst_beat_addr = dinc_l ? (dst_cur + beat_off) : dst_cur;
    assign last_beat     = (size_l != SZ_16) || (beat == BEAT_IDX_W'(LINE_BEATS - 1));
    assign last_unit     = (cnt_rem == {{(CW-1){1'b0}}, 1'b1});
    assign beat_size     = (size_l == SZ_16) ? SZ_4 : size_l;

    a_r5_beat_only_in_line: assert property (@(posedge clk) disable iff (!rst_n)
        (size_l != SZ_16) |-> (beat == '0));

    a_r5_no_advance_past_line: assert property (@(posedge clk) disable iff (!rst_n)
        beat_adv |-> !last_beat);

endmodule

// File: rtl/dma_fsm.sv
module dma_fsm
    import dma_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic          single_in,
    input  logic          dev_src_in,
    input  logic          burst_in,
    input  logic          dreq,
    input  logic          bus_ready,
    input  logic [DW-1:0] bus_rdata,
    input  logic          last_beat,
    input  logic          last_unit,
    output logic          load,
    output logic          beat_adv,
    output logic          unit_adv,
    output logic          use_dst,
    output logic          bus_rd,
    output logic          bus_wr,
    output logic          dack,
    output logic          bus_req,
    output logic          busy,
    output logic          done,
    output logic [DW-1:0] hold_data
);

    dma_state_t state;
    dma_state_t state_nx;
    logic       single_l;
    logic       dev_src_l;
    logic       burst_l;
    logic       beat_end;

    assign beat_end = ((state == ST_WRITE) || (state == ST_SINGLE)) && bus_ready;

    // state register and captured mode bits
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            single_l  <= 1'b0;
            dev_src_l <= 1'b0;
            burst_l   <= 1'b0;
            hold_data <= '0;
        end else begin
            state <= state_nx;
            if (state == ST_IDLE && go) begin
                single_l  <= single_in;
                dev_src_l <= dev_src_in;
                burst_l   <= burst_in;
            end
            if (state == ST_READ && bus_ready) begin
                hold_data <= bus_rdata;
            end
        end
    end

    // next-state selection
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (go) state_nx = single_in ? ST_WREQ : ST_READ;
            ST_WREQ:   if (dreq) state_nx = ST_SINGLE;
            ST_READ:   if (bus_ready) state_nx = ST_WRITE;
            ST_WRITE: begin
                if (bus_ready) begin
                    if (!last_beat)     state_nx = ST_READ;
                    else if (last_unit) state_nx = ST_DONE;
                    else if (burst_l)   state_nx = ST_READ;
                    else                state_nx = ST_GAP;
                end
            end
            ST_SINGLE: begin
                if (bus_ready) begin
                    if (!last_beat)     state_nx = ST_SINGLE;
                    else if (last_unit) state_nx = ST_DONE;
                    else if (burst_l)   state_nx = ST_SINGLE;
                    else                state_nx = ST_GAP;
                end
            end
            ST_GAP:    state_nx = single_l ? ST_WREQ : ST_READ;
            ST_DONE:   state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // outputs decoded from state
    always_comb begin
        load     = 1'b0;
        use_dst  = 1'b0;
        bus_rd   = 1'b0;
        bus_wr   = 1'b0;
        dack     = 1'b0;
        bus_req  = 1'b0;
        busy     = 1'b1;
        done     = 1'b0;
        beat_adv = beat_end && !last_beat;
        unit_adv = beat_end && last_beat;
        unique case (state)
            ST_IDLE: begin
                busy = 1'b0;
                load = go;
            end
            ST_WREQ: begin
            end
            ST_READ: begin
                bus_rd  = 1'b1;
                bus_req = 1'b1;
            end
            ST_WRITE: begin
                bus_wr  = 1'b1;
                bus_req = 1'b1;
                use_dst = 1'b1;
            end
            ST_SINGLE: begin
                bus_req = 1'b1;
                dack    = 1'b1;
                use_dst = dev_src_l;
                bus_wr  = dev_src_l;
                bus_rd  = !dev_src_l;
            end
            ST_GAP: begin
            end
            ST_DONE: begin
                done = 1'b1;
            end
            default: begin
                busy = 1'b0;
            end
        endcase
    end

    a_r3_write_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(bus_wr) && !dack) |-> $past(bus_rd && bus_ready));

    a_r9_done_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    a_r7_steal_releases: assert property (@(posedge clk) disable iff (!rst_n)
        (unit_adv && !last_unit && !burst_l) |=> !bus_req);

    a_r8_dack_after_dreq: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dack) |-> $past(dreq));

endmodule

// File: rtl/dma_channel.sv
module dma_channel
    import dma_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [2:0]    src_type,
    input  logic [2:0]    dst_type,
    input  logic [AW-1:0] src_addr,
    input  logic [AW-1:0] dst_addr,
    input  logic [CW-1:0] xfer_count,
    input  logic [1:0]    unit_size,
    input  logic          src_inc,
    input  logic          dst_inc,
    input  logic          burst_mode,
    input  logic          dreq,
    output logic          dack,
    output logic          bus_req,
    output logic [AW-1:0] bus_addr,
    output logic          bus_rd,
    output logic          bus_wr,
    output logic [1:0]    bus_size,
    output logic [DW-1:0] bus_wdata,
    input  logic [DW-1:0] bus_rdata,
    input  logic          bus_ready,
    output logic          busy,
    output logic          done,
    output logic          error
);

    logic          cfg_ok;
    logic          single_mode;
    logic          dev_is_src;
    logic          go;
    logic          load;
    logic          beat_adv;
    logic          unit_adv;
    logic          use_dst;
    logic          last_beat;
    logic          last_unit;
    logic [AW-1:0] src_beat_addr;
    logic [AW-1:0] dst_beat_addr;

    assign go = start && !busy && cfg_ok;

    dma_legal #(.CW(CW)) u_legal (
        .src_type    (src_type),
        .dst_type    (dst_type),
        .unit_size   (unit_size),
        .xfer_count  (xfer_count),
        .cfg_ok      (cfg_ok),
        .single_mode (single_mode),
        .dev_is_src  (dev_is_src)
    );

    dma_xfer_regs #(.AW(AW), .CW(CW)) u_regs (
        .clk           (clk),
        .rst_n         (rst_n),
        .load          (load),
        .beat_adv      (beat_adv),
        .unit_adv      (unit_adv),
        .src_addr      (src_addr),
        .dst_addr      (dst_addr),
        .xfer_count    (xfer_count),
        .unit_size     (unit_size),
        .src_inc       (src_inc),
        .dst_inc       (dst_inc),
        .src_beat_addr (src_beat_addr),
        .dst_beat_addr (dst_beat_addr),
        .last_beat     (last_beat),
        .last_unit     (last_unit),
        .beat_size     (bus_size)
    );

    dma_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .go         (go),
        .single_in  (single_mode),
        .dev_src_in (dev_is_src),
        .burst_in   (burst_mode),
        .dreq       (dreq),
        .bus_ready  (bus_ready),
        .bus_rdata  (bus_rdata),
        .last_beat  (last_beat),
        .last_unit  (last_unit),
        .load       (load),
        .beat_adv   (beat_adv),
        .unit_adv   (unit_adv),
        .use_dst    (use_dst),
        .bus_rd     (bus_rd),
        .bus_wr     (bus_wr),
        .dack       (dack),
        .bus_req    (bus_req),
        .busy       (busy),
        .done       (done),
        .hold_data  (bus_wdata)
    );

    assign bus_addr = use_dst ? dst_beat_addr : src_beat_addr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            error <= 1'b0;
        end else if (start && !busy) begin
            error <= !cfg_ok;
        end
    end

    a_r1_reject_quietly: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !cfg_ok) |=> (error && !busy && !bus_req));

    a_r10_start_ignored_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (start && busy) |=> $stable(error));

    a_r11_hold_until_ready: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_rd || bus_wr) && !bus_ready) |=>
            ($stable(bus_addr) && $stable(bus_rd) && $stable(bus_wr)));

endmodule

// File: tb/dma_channel_test.sv
`timescale 1ns/1ps
module dma_channel_test;

    typedef struct packed {
        logic        wr;
        logic [31:0] addr;
        logic [31:0] data;
        logic        chkd;
        logic        dk;
        logic [1:0]  sz;
    } beat_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  src_type = 3'd1;
    logic [2:0]  dst_type = 3'd1;
    logic [31:0] src_addr = '0;
    logic [31:0] dst_addr = '0;
    logic [15:0] xfer_count = 16'd1;
    logic [1:0]  unit_size = 2'd0;
    logic        src_inc = 1'b0;
    logic        dst_inc = 1'b0;
    logic        burst_mode = 1'b0;
    logic        dreq = 1'b0;
    logic        dack;
    logic        bus_req;
    logic [31:0] bus_addr;
    logic        bus_rd;
    logic        bus_wr;
    logic [1:0]  bus_size;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata = '0;
    logic        bus_ready = 1'b0;
    logic        busy;
    logic        done;
    logic        error;

    int checks = 0;
    int fails = 0;
    int mon_checks = 0;
    int mon_fails = 0;
    int beats_seen = 0;
    int done_cnt = 0;
    int br_rises = 0;
    int wait_cyc = 0;
    bit dreq_block = 1'b0;
    bit pulse_mode = 1'b0;
    beat_t exp_q[$];

    always #10 clk = ~clk;

    dma_channel uut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .src_type(src_type), .dst_type(dst_type),
        .src_addr(src_addr), .dst_addr(dst_addr),
        .xfer_count(xfer_count), .unit_size(unit_size),
        .src_inc(src_inc), .dst_inc(dst_inc), .burst_mode(burst_mode),
        .dreq(dreq), .dack(dack), .bus_req(bus_req), .bus_addr(bus_addr),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_size(bus_size),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ready(bus_ready),
        .busy(busy), .done(done), .error(error)
    );

    function automatic logic [31:0] memval(input logic [31:0] a);
        return {~a[15:0], a[15:0]} ^ 32'h0F0F_0000;
    endfunction

    function automatic bit legal(input logic [2:0] s, input logic [2:0] d,
                                 input logic [1:0] sz, input logic [15:0] n);
        if (s > 3'd4 || d > 3'd4 || n == 16'd0) return 1'b0;
        if (sz == 2'd3 && (s == 3'd3 || d == 3'd3)) return 1'b0;
        if (s == 3'd0 && d == 3'd0) return 1'b0;
        if (s == 3'd0) return (d == 3'd1 || d == 3'd2);
        if (d == 3'd0) return (s == 3'd1 || s == 3'd2);
        return 1'b1;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // bus responder, dreq source and scoreboard monitor
    int   wcnt = 0;
    int   lo = 0;
    logic prev_req = 1'b0;
    logic prev_dack = 1'b0;
    logic prev_dreq = 1'b0;
    always @(negedge clk) begin
        if (!rst_n) begin
            bus_ready = 1'b0;
            wcnt = 0;
        end else begin
            if (bus_rd || bus_wr) begin
                if (wcnt >= wait_cyc) begin
                    bus_ready = 1'b1;
                    wcnt = 0;
                end else begin
                    bus_ready = 1'b0;
                    wcnt++;
                end
            end else begin
                bus_ready = 1'b0;
                wcnt = 0;
            end
            bus_rdata = memval(bus_addr);
            if (bus_req && !prev_req) br_rises++;
            prev_req = bus_req;
            if (done) done_cnt++;
            if (dack && !prev_dack) begin
                mon_checks++;
                if (!prev_dreq) begin
                    mon_fails++;
                    $display("FAIL R8 dack rose without dreq actual=0 expected=1");
                end
            end
            prev_dack = dack;
            if (bus_ready) begin
                beat_t e;
                beats_seen++;
                mon_checks++;
                if (exp_q.size() == 0) begin
                    mon_fails++;
                    $display("FAIL R1 unexpected bus beat actual=%0h expected=none", bus_addr);
                end else begin
                    e = exp_q.pop_front();
                    if (e.wr != bus_wr || e.dk != dack) begin
                        mon_fails++;
                        $display("FAIL R4 beat kind actual=%0h expected=%0h",
                                 {bus_wr, dack}, {e.wr, e.dk});
                    end else if (e.addr != bus_addr) begin
                        mon_fails++;
                        $display("FAIL R6 beat address actual=%0h expected=%0h",
                                 bus_addr, e.addr);
                    end else if (e.sz != bus_size) begin
                        mon_fails++;
                        $display("FAIL R5 beat size actual=%0h expected=%0h",
                                 bus_size, e.sz);
                    end else if (e.chkd && e.data != bus_wdata) begin
                        mon_fails++;
                        $display("FAIL R3 write data actual=%0h expected=%0h",
                                 bus_wdata, e.data);
                    end
                end
            end
            if (pulse_mode && dack && bus_ready) lo = 3;
            else if (lo > 0) lo--;
            dreq = !dreq_block && (lo == 0);
            prev_dreq = dreq;
        end
    end

    task automatic run(input string req, input logic [2:0] st, input logic [2:0] dt,
                       input logic [31:0] sa, input logic [31:0] da,
                       input logic [15:0] cnt, input logic [1:0] sz,
                       input bit si, input bit di, input bit bm, input int wt,
                       input bit pulse, input bit block_first, input bit restart_at_done);
        int b0;
        int d0;
        int r0;
        int nb;
        int bytes;
        bit ok;
        bit seen;
        ok = legal(st, dt, sz, cnt);
        bytes = (sz == 2'd3) ? 16 : (1 << sz);
        nb = (sz == 2'd3) ? 4 : 1;
        if (ok) begin
            for (int u = 0; u < cnt; u++) begin
                for (int b = 0; b < nb; b++) begin
                    logic [31:0] a_s;
                    logic [31:0] a_d;
                    beat_t e;
                    a_s = si ? (sa + u * bytes + b * 4) : sa;
                    a_d = di ? (da + u * bytes + b * 4) : da;
                    e.sz = (sz == 2'd3) ? 2'd2 : sz;
                    if (st == 3'd0) begin
                        e.wr = 1'b1; e.addr = a_d; e.data = '0; e.chkd = 1'b0; e.dk = 1'b1;
                        exp_q.push_back(e);
                    end else if (dt == 3'd0) begin
                        e.wr = 1'b0; e.addr = a_s; e.data = '0; e.chkd = 1'b0; e.dk = 1'b1;
                        exp_q.push_back(e);
                    end else begin
                        e.wr = 1'b0; e.addr = a_s; e.data = '0; e.chkd = 1'b0; e.dk = 1'b0;
                        exp_q.push_back(e);
                        e.wr = 1'b1; e.addr = a_d; e.data = memval(a_s); e.chkd = 1'b1;
                        exp_q.push_back(e);
                    end
                end
            end
        end
        @(negedge clk);
        src_type = st; dst_type = dt; src_addr = sa; dst_addr = da;
        xfer_count = cnt; unit_size = sz; src_inc = si; dst_inc = di;
        burst_mode = bm; wait_cyc = wt; pulse_mode = pulse; dreq_block = block_first;
        b0 = beats_seen; d0 = done_cnt; r0 = br_rises;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (!ok) begin
            chk(error == 1'b1 && busy == 1'b0, req, "illegal start flags error", {error, busy}, 2'b10);
            repeat (6) @(negedge clk);
            chk(beats_seen == b0 && !bus_req, req, "no bus cycle after rejection", beats_seen - b0, 0);
            return;
        end
        chk(error == 1'b0 && busy == 1'b1, "R9", "legal start clears error", {error, busy}, 2'b01);
        if (block_first) begin
            repeat (8) @(negedge clk);
            chk(beats_seen == b0 && dack == 1'b0, "R8", "no cycle while dreq low", beats_seen - b0, 0);
            dreq_block = 1'b0;
        end
        seen = 1'b0;
        for (int t = 0; t < 4000 && !seen; t++) begin
            @(negedge clk);
            if (done) begin
                seen = 1'b1;
                if (restart_at_done) start = 1'b1;
            end
        end
        chk(seen, req, "done pulse seen", seen, 1);
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b0 && done == 1'b0, "R9", "idle after done", {busy, done}, 2'b00);
        chk(exp_q.size() == 0, "R11", "all expected beats completed", exp_q.size(), 0);
        chk(br_rises - r0 == (bm ? 1 : int'(cnt)), "R7", "bus_req rises",
            br_rises - r0, bm ? 1 : cnt);
        if (restart_at_done) begin
            b0 = beats_seen;
            repeat (10) @(negedge clk);
            chk(beats_seen == b0 && busy == 1'b0, "R10", "start in done cycle ignored",
                beats_seen - b0, 0);
        end
        chk(done_cnt - d0 == 1, "R9", "exactly one done pulse", done_cnt - d0, 1);
        wait_cyc = 0; pulse_mode = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("%0d/%0d checks passed", checks + mon_checks - fails - mon_fails,
                 checks + mon_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(busy == 0 && bus_rd == 0 && bus_wr == 0 && dack == 0 && error == 0 && done == 0,
            "R9", "reset state", {busy, bus_rd, bus_wr, dack, error, done}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        // illegal pairings and parameters (R1, R2)
        run("R1", 3'd0, 3'd0, 32'h100, 32'h200, 16'd2, 2'd2, 1, 1, 1, 0, 0, 0, 0);
        run("R1", 3'd0, 3'd3, 32'h100, 32'h200, 16'd2, 2'd2, 1, 1, 1, 0, 0, 0, 0);
        run("R1", 3'd4, 3'd0, 32'h100, 32'h200, 16'd2, 2'd2, 1, 1, 1, 0, 0, 0, 0);
        run("R1", 3'd5, 3'd1, 32'h100, 32'h200, 16'd2, 2'd2, 1, 1, 1, 0, 0, 0, 0);
        run("R1", 3'd1, 3'd2, 32'h100, 32'h200, 16'd0, 2'd2, 1, 1, 1, 0, 0, 0, 0);
        run("R2", 3'd3, 3'd1, 32'h100, 32'h200, 16'd1, 2'd3, 1, 1, 1, 0, 0, 0, 0);
        run("R2", 3'd4, 3'd3, 32'h100, 32'h200, 16'd1, 2'd3, 1, 1, 1, 0, 0, 0, 0);
        // dual address, burst, 4-byte units (R3, R6)
        run("R3", 3'd1, 3'd2, 32'h1000, 32'h2000, 16'd3, 2'd2, 1, 1, 1, 0, 0, 0, 0);
        // dual, cycle-steal, byte units, fixed source, wait states (R7, R11)
        run("R7", 3'd3, 3'd4, 32'h3003, 32'h4001, 16'd3, 2'd0, 0, 1, 0, 2, 0, 0, 0);
        // 16-byte units, both incrementing (R5)
        run("R5", 3'd1, 3'd4, 32'h5000, 32'h6000, 16'd2, 2'd3, 1, 1, 1, 1, 0, 0, 0);
        // 16-byte unit to a fixed destination (R5, R6)
        run("R6", 3'd2, 3'd1, 32'h7000, 32'h8000, 16'd1, 2'd3, 1, 0, 0, 0, 0, 0, 0);
        // single address: device source, cycle-steal, paced by dreq (R4, R8)
        run("R4", 3'd0, 3'd1, 32'h0, 32'h9000, 16'd3, 2'd1, 0, 1, 0, 1, 1, 1, 0);
        // single address: device destination, burst, 16-byte units (R4, R5)
        run("R4", 3'd2, 3'd0, 32'hA000, 32'h0, 16'd2, 2'd3, 1, 0, 1, 0, 0, 1, 0);
        // start coinciding with done (R10)
        run("R10", 3'd1, 3'd1, 32'hB000, 32'hC000, 16'd2, 2'd1, 1, 1, 0, 0, 0, 0, 1);
        repeat (4) @(negedge clk);
        chk(mon_fails == 0, "R3", "scoreboard mismatches", mon_fails, 0);
        $display("%0d/%0d checks passed", checks + mon_checks - fails - mon_fails,
                 checks + mon_checks);
        $finish;
    end

endmodule